// File: doc/BRIEF.md
# Stepped Radix Divider with Mode-Dependent Operand Preparation

The block divides a dividend by a divisor over a fixed, short sequence of externally paced iterations. A one-cycle `start_i` pulse captures the operands and the mode. Each following one-cycle `step_i` strobe advances the division by one iteration. Between strobes the partial remainder, the partial quotient and the unconsumed dividend bits are held, so the sequence can pause for any number of cycles. Modes with a 16-bit divisor need 6 strobes. Modes with a 32-bit divisor need 10 strobes.

The first strobe checks the selected divisor for zero. It also prepares the operands: extension, fractional scaling and conversion to magnitudes. Later strobes retire quotient bits by restoring subtraction on magnitudes. The final strobe applies the sign correction and registers the quotient, the remainder and four condition flags. `done_o` then pulses for one cycle.

The controller has three states. IDLE waits for `start_i`. ARMED holds captured operands until the first strobe. RUN counts the remaining strobes. The named transitions are:
- `launch`: any state to ARMED when `start_i` is high.
- `trap_exit`: ARMED to IDLE on a strobe that finds a zero divisor.
- `begin`: ARMED to RUN on a strobe with a non-zero divisor.
- `advance`: RUN to RUN on any strobe except the last.
- `finish`: RUN to IDLE on the last strobe.

Top module: `divstep_unit`

## Requirements
- R1: Mode encoding on `mode_i`: 0 unsigned 16/16, 1 signed 16/16, 2 unsigned 32/16, 3 signed 32/16, 4 fractional 16/16, 5 fractional 32/16, 6 unsigned 32/32, 7 signed 32/32. Modes 0 to 5 complete on exactly the 6th strobe after start. Modes 6 and 7 complete on exactly the 10th. `done_o` is high for exactly the one cycle after the completing strobe's clock edge, and low at every other time.
- R2: Cycles without a strobe do not change the progress or the result. Any number of idle cycles between strobes gives the same outputs as back-to-back strobes.
- R3: In 16/16 modes only `dividend_i[15:0]` is used. Mode 0 zero-extends it and mode 1 sign-extends it from bit 15. In all 16-bit-divisor modes only `divisor_i[15:0]` is used. It is sign-extended from bit 15 in signed modes and zero-extended otherwise.
- R4: Mode 4 uses `dividend_i[15:0]` shifted left by 16, with zeros in the low half, as a signed 32-bit dividend. Mode 5 uses the full 32-bit signed dividend and gives the same results as mode 3.
- R5: In 16-bit-divisor modes the quotient and the remainder are the low 16 bits of the truncated integer results. Bits [31:16] of both outputs are zero.
- R6: The quotient is rounded toward zero. A non-zero remainder has the sign of the dividend.
- R7: A zero divisor seen on the first strobe causes the following effects:
  - `div_zero_trap_o` is high for one cycle after that edge.
  - `done_o` never rises for that sequence.
  - The quotient, remainder and flags keep their previous values.
  - Further strobes are ignored until the next start.
- R8: `flag_z_o` is 1 when the remainder output is zero. `flag_n_o` is 1 when the remainder is negative, and is always 0 in modes 0, 2 and 6.
- R9: `flag_ov_o` is 1 when the true quotient does not fit the result width. That width is signed or unsigned 16 bits for 16-bit-divisor modes, and signed 32 bits for mode 7. The flag is always 0 in modes 0 and 6. When it is set, the quotient, remainder and other flags are unspecified.
- R10: `flag_c_o` equals bit 0 of the quotient's magnitude.
- R11: A start pulse abandons any sequence in progress and begins a new one. A strobe in the same cycle as a start pulse is ignored.
- R12: After reset all outputs are zero. A strobe that arrives with no sequence pending changes nothing.
- R13: Modes 6 and 7 return the full 32-bit quotient and remainder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture operands and mode, begin a sequence |
| step_i | input | 1 | Iteration strobe |
| mode_i | input | 3 | Division mode, captured at start |
| dividend_i | input | 32 | Dividend, captured at start |
| divisor_i | input | 32 | Divisor, captured at start |
| quotient_o | output | 32 | Quotient of the last completed sequence |
| remainder_o | output | 32 | Remainder of the last completed sequence |
| flag_c_o | output | 1 | Quotient magnitude bit 0 |
| flag_n_o | output | 1 | Remainder negative |
| flag_ov_o | output | 1 | Quotient overflow |
| flag_z_o | output | 1 | Remainder zero |
| div_zero_trap_o | output | 1 | One-cycle zero-divisor trap |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The sweep crosses every mode with dividends and divisors at the sign boundaries: 0x7FFF, 0x8000, 0xFFFF, 0x80000000 and all ones. It also varies the idle gap between strobes. A design that extended the wrong way, or read the upper half in 16-bit modes, returns wrong quotients for negative 16-bit values. A wrong remainder sign shows up as a mismatch when the dividend is negative. Overflow is probed at 0x80000000 / -1, at 0x8000 / -1 in 16/16 signed, and with high dividend halves at or above the divisor; an off-by-one bound flags a fitting -32768 or misses +32768. A zero divisor is tested with extra strobes after the trap, which catches a design that keeps iterating or overwrites the held result. A start pulse in mid-sequence, or together with a strobe, exposes a step counter that is not cleared or a strobe that is counted.

// File: rtl/divstep_pkg.sv
package divstep_pkg;

    typedef enum logic [2:0] {
        MD_U16   = 3'd0,
        MD_S16   = 3'd1,
        MD_U32S  = 3'd2,
        MD_S32S  = 3'd3,
        MD_F16   = 3'd4,
        MD_F32   = 3'd5,
        MD_U32L  = 3'd6,
        MD_S32L  = 3'd7
    } div_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } div_state_e;

    function automatic logic mode_is_long(input div_mode_e m);
        return (m == MD_U32L) || (m == MD_S32L);
    endfunction

    function automatic logic mode_is_signed(input div_mode_e m);
        return !((m == MD_U16) || (m == MD_U32S) || (m == MD_U32L));
    endfunction

endpackage

// File: rtl/divstep_prep.sv
module divstep_prep
    import divstep_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  div_mode_e          mode,
    input  logic [DATA_W-1:0]  dvd,
    input  logic [DATA_W-1:0]  dvs,
    output logic [DATA_W-1:0]  num_mag,
    output logic [DATA_W-1:0]  den_mag,
    output logic               num_neg,
    output logic               den_neg,
    output logic               den_zero,
    output logic               hi_ovf
);
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] num_ext;
    logic [DATA_W-1:0] den_ext;
    logic              sgn;
    logic              lng;

    assign sgn = mode_is_signed(mode);
    assign lng = mode_is_long(mode);

    always_comb begin
        case (mode)
            MD_U16:  num_ext = {{HALF{1'b0}}, dvd[HALF-1:0]};
            MD_S16:  num_ext = {{HALF{dvd[HALF-1]}}, dvd[HALF-1:0]};
            MD_F16:  num_ext = {dvd[HALF-1:0], {HALF{1'b0}}};
            default: num_ext = dvd;
        endcase
    end

    always_comb begin
        if (lng)
            den_ext = dvs;
        else if (sgn)
            den_ext = {{HALF{dvs[HALF-1]}}, dvs[HALF-1:0]};
        else
            den_ext = {{HALF{1'b0}}, dvs[HALF-1:0]};
    end

    assign num_neg  = sgn && num_ext[DATA_W-1];
    assign den_neg  = sgn && den_ext[DATA_W-1];
    assign num_mag  = num_neg ? (~num_ext + 1'b1) : num_ext;
    assign den_mag  = den_neg ? (~den_ext + 1'b1) : den_ext;
    assign den_zero = (den_ext == '0);
    // the upper magnitude half must stay below the divisor for the quotient to fit in HALF bits
    assign hi_ovf   = !lng && ({{HALF{1'b0}}, num_mag[DATA_W-1:HALF]} >= den_mag);

endmodule

// File: rtl/divstep_slices.sv
module divstep_slices #(
    parameter int DATA_W = 32,
    parameter int SLICES = 4,
    parameter int CNT_W  = $clog2(SLICES + 1)
) (
    input  logic [DATA_W-1:0] rem_i,
    input  logic [DATA_W-1:0] feed_i,
    input  logic [DATA_W-1:0] quo_i,
    input  logic [DATA_W-1:0] den_i,
    input  logic [CNT_W-1:0]  nbits_i,
    output logic [DATA_W-1:0] rem_o,
    output logic [DATA_W-1:0] feed_o,
    output logic [DATA_W-1:0] quo_o
);
    logic [DATA_W-1:0] rem_c  [SLICES+1];
    logic [DATA_W-1:0] feed_c [SLICES+1];
    logic [DATA_W-1:0] quo_c  [SLICES+1];

    assign rem_c[0]  = rem_i;
    assign feed_c[0] = feed_i;
    assign quo_c[0]  = quo_i;

    for (genvar g = 0; g < SLICES; g++) begin : g_slice
        logic [DATA_W:0] shifted;
        logic            take;
        logic            active;

        assign active  = (CNT_W'(g) < nbits_i);
        assign shifted = {rem_c[g], feed_c[g][DATA_W-1]};
        assign take    = (shifted >= {1'b0, den_i});

        assign rem_c[g+1]  = active ? DATA_W'(take ? (shifted - {1'b0, den_i}) : shifted)
                                    : rem_c[g];
        assign feed_c[g+1] = active ? {feed_c[g][DATA_W-2:0], 1'b0} : feed_c[g];
        assign quo_c[g+1]  = active ? {quo_c[g][DATA_W-2:0], take} : quo_c[g];
    end

    assign rem_o  = rem_c[SLICES];
    assign feed_o = feed_c[SLICES];
    assign quo_o  = quo_c[SLICES];

endmodule

// File: rtl/divstep_post.sv
module divstep_post
    import divstep_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  div_mode_e          mode,
    input  logic [DATA_W-1:0]  quo_mag,
    input  logic [DATA_W-1:0]  rem_mag,
    input  logic               num_neg,
    input  logic               den_neg,
    input  logic               hi_ovf,
    output logic [DATA_W-1:0]  quotient,
    output logic [DATA_W-1:0]  remainder,
    output logic               fc,
    output logic               fn,
    output logic               fov,
    output logic               fz
);
    localparam int HALF = DATA_W / 2;
    localparam logic [HALF-1:0] HALF_MIN = {1'b1, {(HALF-1){1'b0}}};

    logic            sgn;
    logic            lng;
    logic            q_neg;
    logic [HALF-1:0] q_short;
    logic [HALF-1:0] r_short;
    logic [DATA_W-1:0] q_long;
    logic [DATA_W-1:0] r_long;

    assign sgn   = mode_is_signed(mode);
    assign lng   = mode_is_long(mode);
    assign q_neg = sgn && (num_neg ^ den_neg);

    assign q_short = q_neg   ? (~quo_mag[HALF-1:0] + 1'b1) : quo_mag[HALF-1:0];
    assign r_short = num_neg ? (~rem_mag[HALF-1:0] + 1'b1) : rem_mag[HALF-1:0];
    assign q_long  = q_neg   ? (~quo_mag + 1'b1) : quo_mag;
    assign r_long  = num_neg ? (~rem_mag + 1'b1) : rem_mag;

    always_comb begin
        if (lng) begin
            quotient  = q_long;
            remainder = r_long;
            fov       = sgn && !q_neg && quo_mag[DATA_W-1];
            fn        = sgn && r_long[DATA_W-1];
        end else begin
            quotient  = {{HALF{1'b0}}, q_short};
            remainder = {{HALF{1'b0}}, r_short};
            fov       = hi_ovf || (sgn && (q_neg ? (quo_mag[HALF-1:0] > HALF_MIN)
                                                 : quo_mag[HALF-1]));
            fn        = sgn && r_short[HALF-1];
        end
        fz = (remainder == '0);
        fc = quo_mag[0];
    end

endmodule

// File: rtl/divstep_unit.sv
module divstep_unit
    import divstep_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int SLICES      = 4,
    parameter int SHORT_STEPS = 6,
    parameter int LONG_STEPS  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              step_i,
    input  logic [2:0]        mode_i,
    input  logic [DATA_W-1:0] dividend_i,
    input  logic [DATA_W-1:0] divisor_i,
    output logic [DATA_W-1:0] quotient_o,
    output logic [DATA_W-1:0] remainder_o,
    output logic              flag_c_o,
    output logic              flag_n_o,
    output logic              flag_ov_o,
    output logic              flag_z_o,
    output logic              div_zero_trap_o,
    output logic              done_o
);
    localparam int HALF        = DATA_W / 2;
    localparam int SHORT_BITS  = SLICES - 1;
    localparam int SHORT_FIRST = HALF - (SHORT_STEPS - 1) * SHORT_BITS;
    localparam int LONG_BITS   = DATA_W / (LONG_STEPS - 2);
    localparam int CNT_W       = $clog2(SLICES + 1);
    localparam int STEP_W      = $clog2(LONG_STEPS);

    div_state_e        state_q, state_d;
    div_mode_e         mode_q;
    logic [DATA_W-1:0] dvd_q, dvs_q;
    logic [STEP_W-1:0] idx_q;
    logic [DATA_W-1:0] rem_q, feed_q, quo_q, den_q;
    logic              num_neg_q, den_neg_q, hi_ovf_q;

    logic [DATA_W-1:0] p_num_mag, p_den_mag;
    logic              p_num_neg, p_den_neg, p_den_zero, p_hi_ovf;

    logic [DATA_W-1:0] s_rem_in, s_feed_in, s_quo_in, s_den_in;
    logic [CNT_W-1:0]  s_nbits;
    logic [DATA_W-1:0] s_rem, s_feed, s_quo;

    logic [DATA_W-1:0] o_quo, o_rem;
    logic              o_c, o_n, o_ov, o_z;

    logic              adv;
    logic              lng;
    logic              last;
    logic              fire_done;
    logic              fire_trap;

    assign adv  = step_i && !start_i;
    assign lng  = mode_is_long(mode_q);
    assign last = lng ? (idx_q == STEP_W'(LONG_STEPS - 1))
                      : (idx_q == STEP_W'(SHORT_STEPS - 1));

    divstep_prep #(.DATA_W(DATA_W)) u_prep (
        .mode     (mode_q),
        .dvd      (dvd_q),
        .dvs      (dvs_q),
        .num_mag  (p_num_mag),
        .den_mag  (p_den_mag),
        .num_neg  (p_num_neg),
        .den_neg  (p_den_neg),
        .den_zero (p_den_zero),
        .hi_ovf   (p_hi_ovf)
    );

    // slice inputs: prepared operands on the first strobe, held state afterwards
    always_comb begin
        if (state_q == ST_ARMED) begin
            if (lng) begin
                s_rem_in  = '0;
                s_feed_in = p_num_mag;
                s_nbits   = '0;
            end else begin
                s_rem_in  = {{HALF{1'b0}}, p_num_mag[DATA_W-1:HALF]};
                s_feed_in = {p_num_mag[HALF-1:0], {HALF{1'b0}}};
                s_nbits   = CNT_W'(SHORT_FIRST);
            end
            s_quo_in = '0;
            s_den_in = p_den_mag;
        end else begin
            s_rem_in  = rem_q;
            s_feed_in = feed_q;
            s_quo_in  = quo_q;
            s_den_in  = den_q;
            if (lng)
                s_nbits = last ? '0 : CNT_W'(LONG_BITS);
            else
                s_nbits = CNT_W'(SHORT_BITS);
        end
    end

    divstep_slices #(.DATA_W(DATA_W), .SLICES(SLICES), .CNT_W(CNT_W)) u_slices (
        .rem_i   (s_rem_in),
        .feed_i  (s_feed_in),
        .quo_i   (s_quo_in),
        .den_i   (s_den_in),
        .nbits_i (s_nbits),
        .rem_o   (s_rem),
        .feed_o  (s_feed),
        .quo_o   (s_quo)
    );

    divstep_post #(.DATA_W(DATA_W)) u_post (
        .mode      (mode_q),
        .quo_mag   (s_quo),
        .rem_mag   (s_rem),
        .num_neg   (num_neg_q),
        .den_neg   (den_neg_q),
        .hi_ovf    (hi_ovf_q),
        .quotient  (o_quo),
        .remainder (o_rem),
        .fc        (o_c),
        .fn        (o_n),
        .fov       (o_ov),
        .fz        (o_z)
    );

    // next-state: launch / trap_exit / begin / advance / finish
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = ST_ARMED;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_ARMED: if (step_i) state_d = p_den_zero ? ST_IDLE : ST_RUN;
                ST_RUN:   if (step_i && last) state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    assign fire_done = adv && (state_q == ST_RUN) && last;
    assign fire_trap = adv && (state_q == ST_ARMED) && p_den_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // iteration datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= MD_U16;
            dvd_q     <= '0;
            dvs_q     <= '0;
            idx_q     <= '0;
            rem_q     <= '0;
            feed_q    <= '0;
            quo_q     <= '0;
            den_q     <= '0;
            num_neg_q <= 1'b0;
            den_neg_q <= 1'b0;
            hi_ovf_q  <= 1'b0;
        end else if (start_i) begin
            mode_q <= div_mode_e'(mode_i);
            dvd_q  <= dividend_i;
            dvs_q  <= divisor_i;
            idx_q  <= '0;
        end else if (adv && (state_q == ST_ARMED) && !p_den_zero) begin
            rem_q     <= s_rem;
            feed_q    <= s_feed;
            quo_q     <= s_quo;
            den_q     <= p_den_mag;
            num_neg_q <= p_num_neg;
            den_neg_q <= p_den_neg;
            hi_ovf_q  <= p_hi_ovf;
            idx_q     <= idx_q + 1'b1;
        end else if (adv && (state_q == ST_RUN)) begin
            rem_q  <= s_rem;
            feed_q <= s_feed;
            quo_q  <= s_quo;
            idx_q  <= idx_q + 1'b1;
        end
    end

    // result and pulse outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quotient_o      <= '0;
            remainder_o     <= '0;
            flag_c_o        <= 1'b0;
            flag_n_o        <= 1'b0;
            flag_ov_o       <= 1'b0;
            flag_z_o        <= 1'b0;
            done_o          <= 1'b0;
            div_zero_trap_o <= 1'b0;
        end else begin
            done_o          <= fire_done;
            div_zero_trap_o <= fire_trap;
            if (fire_done) begin
                quotient_o  <= o_quo;
                remainder_o <= o_rem;
                flag_c_o    <= o_c;
                flag_n_o    <= o_n;
                flag_ov_o   <= o_ov;
                flag_z_o    <= o_z;
            end
        end
    end

endmodule

// File: rtl/divstep_checker.sv
module divstep_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        step_i,
    input logic [2:0]  mode_q,
    input logic [31:0] quotient_o,
    input logic [31:0] remainder_o,
    input logic        flag_n_o,
    input logic        flag_ov_o,
    input logic        flag_z_o,
    input logic        div_zero_trap_o,
    input logic        done_o
);
    logic short_m;
    logic unsigned_m;
    assign short_m    = (mode_q[2:1] != 2'b11);
    assign unsigned_m = (mode_q == 3'd0) || (mode_q == 3'd2) || (mode_q == 3'd6);

    p_done_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_after_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(step_i && !start_i));

    p_trap_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero_trap_o |=> !div_zero_trap_o);

    p_trap_excl_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(div_zero_trap_o && done_o));

    p_result_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(quotient_o) && $stable(remainder_o)));

    p_upper_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && short_m) |-> (quotient_o[31:16] == 16'h0 && remainder_o[31:16] == 16'h0));

    p_n_excl_z_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !(flag_n_o && flag_z_o));

    p_z_matches_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (flag_z_o == (remainder_o == 32'h0)));

    p_unsigned_no_neg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && unsigned_m) |-> !flag_n_o);

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (mode_q == 3'd0 || mode_q == 3'd6)) |-> !flag_ov_o);

endmodule

bind divstep_unit divstep_checker u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .step_i          (step_i),
    .mode_q          (mode_q),
    .quotient_o      (quotient_o),
    .remainder_o     (remainder_o),
    .flag_n_o        (flag_n_o),
    .flag_ov_o       (flag_ov_o),
    .flag_z_o        (flag_z_o),
    .div_zero_trap_o (div_zero_trap_o),
    .done_o          (done_o)
);

// File: tb/sim_divstep_unit.sv
`timescale 1ns/1ps
module sim_divstep_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        step_i = 1'b0;
    logic [2:0]  mode_i = 3'd0;
    logic [31:0] dividend_i = '0;
    logic [31:0] divisor_i = '0;
    logic [31:0] quotient_o, remainder_o;
    logic        flag_c_o, flag_n_o, flag_ov_o, flag_z_o, div_zero_trap_o, done_o;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    divstep_unit u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .step_i(step_i),
        .mode_i(mode_i), .dividend_i(dividend_i), .divisor_i(divisor_i),
        .quotient_o(quotient_o), .remainder_o(remainder_o),
        .flag_c_o(flag_c_o), .flag_n_o(flag_n_o), .flag_ov_o(flag_ov_o),
        .flag_z_o(flag_z_o), .div_zero_trap_o(div_zero_trap_o), .done_o(done_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] dvd_val(input int i);
        case (i)
            0: return 32'h0;          1: return 32'h1;
            2: return 32'h2;          3: return 32'h3000;
            4: return 32'h7FFF;       5: return 32'h8000;
            6: return 32'hFFFF;       7: return 32'h10000;
            8: return 32'h12345678;   9: return 32'h7FFFFFFF;
            10: return 32'h80000000;  11: return 32'hFFFFFFFF;
            12: return 32'hFFFF8000;  default: return 32'hFFFFCFF9;
        endcase
    endfunction

    function automatic logic [31:0] dvs_val(input int j);
        case (j)
            0: return 32'h0;          1: return 32'h1;
            2: return 32'h3;          3: return 32'h27;
            4: return 32'h7FFF;       5: return 32'h8000;
            6: return 32'hFFFF;       7: return 32'h10000;
            8: return 32'hFFFFFFFF;   9: return 32'h80000000;
            10: return 32'h1234;      default: return 32'hFFFFFFF9;
        endcase
    endfunction

    task automatic model(input logic [2:0] m, input logic [31:0] a, input logic [31:0] b,
                         output logic [31:0] eq, output logic [31:0] er,
                         output logic ec, output logic en, output logic eov,
                         output logic ez, output logic etrap, output int nst);
        longint n, d, q, r;
        bit sgn;
        sgn = !(m == 3'd0 || m == 3'd2 || m == 3'd6);
        case (m)
            3'd0: begin n = longint'({48'h0, a[15:0]}); d = longint'({48'h0, b[15:0]}); end
            3'd1: begin n = longint'($signed(a[15:0])); d = longint'($signed(b[15:0])); end
            3'd2: begin n = longint'({32'h0, a}); d = longint'({48'h0, b[15:0]}); end
            3'd4: begin n = longint'($signed(a[15:0])) * 65536; d = longint'($signed(b[15:0])); end
            3'd6: begin n = longint'({32'h0, a}); d = longint'({32'h0, b}); end
            3'd7: begin n = longint'($signed(a)); d = longint'($signed(b)); end
            default: begin n = longint'($signed(a)); d = longint'($signed(b[15:0])); end
        endcase
        nst = (m >= 3'd6) ? 10 : 6;
        etrap = (d == 0);
        eq = '0; er = '0; ec = 0; en = 0; eov = 0; ez = 0;
        if (!etrap) begin
            q = n / d;
            r = n % d;
            if (m == 3'd2)      eov = (q > 65535);
            else if (m == 3'd7) eov = (q > 64'sd2147483647);
            else if (m < 3'd6 && sgn) eov = (q > 32767) || (q < -32768);
            if (m >= 3'd6) begin eq = q[31:0]; er = r[31:0]; end
            else begin eq = {16'h0, q[15:0]}; er = {16'h0, r[15:0]}; end
            ec = q[0];
            ez = (r == 0);
            en = sgn && (r < 0);
        end
    endtask

    task automatic do_start(input logic [2:0] m, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        start_i = 1'b1; mode_i = m; dividend_i = a; divisor_i = b;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic do_step(input int gap);
        repeat (gap) @(negedge clk);
        step_i = 1'b1;
        @(negedge clk);
        step_i = 1'b0;
    endtask

    task automatic run_vec(input logic [2:0] m, input logic [31:0] a, input logic [31:0] b,
                           input int gap);
        logic [31:0] eq, er, pq, pr;
        logic ec, en, eov, ez, etrap;
        int nst;
        string tq;
        model(m, a, b, eq, er, ec, en, eov, ez, etrap, nst);
        tq = (m <= 3'd1) ? "R3" : (m == 3'd4 || m == 3'd5) ? "R4" : (m >= 3'd6) ? "R13" : "R5";
        pq = quotient_o; pr = remainder_o;
        do_start(m, a, b);
        for (int s = 0; s < nst; s++) begin
            do_step(gap);
            if (etrap) begin
                chk("R7 trap pulse", {31'h0, div_zero_trap_o}, 32'h1);
                chk("R7 no done", {31'h0, done_o}, 32'h0);
                do_step(0);
                do_step(1);
                chk("R7 ignored strobes", {31'h0, done_o}, 32'h0);
                chk("R7 quotient held", quotient_o, pq);
                chk("R7 remainder held", remainder_o, pr);
                break;
            end
            if (s < nst - 1) begin
                chk(gap > 0 ? "R2 early done" : "R1 early done", {31'h0, done_o}, 32'h0);
            end else begin
                chk(gap > 0 ? "R2 done" : "R1 done", {31'h0, done_o}, 32'h1);
                chk("R9 ov", {31'h0, flag_ov_o}, {31'h0, eov});
                if (!eov) begin
                    chk(tq, quotient_o, eq);
                    chk((m == 3'd0 || m == 3'd2 || m == 3'd6) ? "R5 rem" : "R6 rem",
                        remainder_o, er);
                    chk("R10 c", {31'h0, flag_c_o}, {31'h0, ec});
                    chk("R8 n", {31'h0, flag_n_o}, {31'h0, en});
                    chk("R8 z", {31'h0, flag_z_o}, {31'h0, ez});
                end
                @(negedge clk);
                chk("R1 done one cycle", {31'h0, done_o}, 32'h0);
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 quotient reset", quotient_o, 32'h0);
        chk("R12 remainder reset", remainder_o, 32'h0);
        chk("R12 flags reset", {26'h0, flag_c_o, flag_n_o, flag_ov_o, flag_z_o,
                                div_zero_trap_o, done_o}, 32'h0);
        // R12 stray strobes without a sequence
        do_step(0);
        do_step(2);
        chk("R12 stray strobe done", {31'h0, done_o}, 32'h0);
        chk("R12 stray strobe quotient", quotient_o, 32'h0);

        // documented example: signed 32/16, 0x3000 / 0x27
        run_vec(3'd3, 32'h3000, 32'h27, 0);
        chk("R5 example quotient", quotient_o, 32'h013B);
        chk("R5 example remainder", remainder_o, 32'h3);

        // sweep
        for (int m = 0; m < 8; m++)
            for (int i = 0; i < 14; i++)
                for (int j = 0; j < 12; j++)
                    run_vec(3'(m), dvd_val(i), dvs_val(j), (i + j + m) % 3);

        // R11 restart mid-sequence
        do_start(3'd7, 32'd100, 32'd7);
        do_step(0); do_step(0); do_step(1);
        do_start(3'd1, 32'h3000, 32'h27);
        for (int s = 0; s < 5; s++) begin
            do_step(0);
            chk("R11 restart early done", {31'h0, done_o}, 32'h0);
        end
        do_step(0);
        chk("R11 restart done", {31'h0, done_o}, 32'h1);
        chk("R11 restart quotient", quotient_o, 32'h013B);
        chk("R11 restart remainder", remainder_o, 32'h3);

        // R11 strobe together with start is ignored
        @(negedge clk);
        start_i = 1'b1; step_i = 1'b1; mode_i = 3'd0; dividend_i = 32'd50; divisor_i = 32'd7;
        @(negedge clk);
        start_i = 1'b0; step_i = 1'b0;
        for (int s = 0; s < 5; s++) begin
            do_step(0);
            chk("R11 same-cycle early done", {31'h0, done_o}, 32'h0);
        end
        do_step(0);
        chk("R11 same-cycle done", {31'h0, done_o}, 32'h1);
        chk("R11 same-cycle quotient", quotient_o, 32'd7);
        chk("R11 same-cycle remainder", remainder_o, 32'd1);

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule